// File: doc/BRIEF.md
# Two-Entry Operand-Wait Reservation Station

This block is a two-slot holding buffer placed in front of one execution unit. The dispatch stage hands it instructions whose source operands may still be outstanding. The buffer keeps each instruction until both of its operands are present, so the dispatch stage does not have to stall. While an instruction waits, each of its pending sources watches a result broadcast bus. When a broadcast carries the rename tag that the source is waiting for, the source takes the broadcast data.

Instructions are held in program order, with slot 0 always holding the older one. An entry whose operands arrive by broadcast becomes eligible to issue one cycle after that broadcast. A compile-time parameter selects the issue policy. In in-order mode, only the oldest entry may go to the execution unit. In out-of-order mode, any entry with both operands present may go, and the older entry wins when both are ready.

Both data interfaces use valid/ready handshakes. A dispatch transfers on a cycle where `disp_valid` and `disp_ready` are both high. An issue transfers on a cycle where `iss_valid` and `iss_ready` are both high. The station never withdraws `iss_valid` while the execution unit applies back-pressure, except when a flush arrives. In out-of-order mode the offered instruction may change to an older one while `iss_ready` stays low. The broadcast port and the flush input are plain control inputs and have no handshake.

Top module: `opwait_station`

## Requirements
- R1: After reset the station is empty: `iss_valid` is low and `disp_ready` is high.
- R2: An instruction is accepted even when one or both of its sources are flagged not ready. `disp_ready` is high whenever fewer than two entries are held and `flush` is low.
- R3: When both entries are held, `disp_ready` is low unless an issue handshake occurs in the same cycle. If an issue handshake does occur, `disp_ready` is high and the freed slot can be refilled at that edge.
- R4: A pending source whose tag equals `bc_tag` while `bc_valid` is high takes `bc_data`. The entry can issue from the cycle after the broadcast, and not in the broadcast cycle itself. A broadcast with a different tag changes nothing.
- R5: A broadcast in the same cycle as the dispatch that brings a matching pending source is captured by that source.
- R6: In in-order mode (POLICY = POLICY_IN_ORDER), only the oldest held entry may issue. A younger entry that is ready waits behind an older entry that is not.
- R7: In out-of-order mode (POLICY = POLICY_OUT_OF_ORDER), any entry with both operands present may issue. When both entries are ready, the older one is offered.
- R8: An entry leaves only on an issue handshake. At most one entry issues per cycle. `iss_valid` stays high while `iss_ready` is low and no flush occurs.
- R9: While `flush` is high, `iss_valid` and `disp_ready` are low. On the next cycle no entry remains, and later broadcasts do not bring a flushed entry back.
- R10: The values on `iss_op`, `iss_a` and `iss_b` are the dispatched opcode and the operand values. An operand value is the dispatched value if that source was ready at dispatch, or otherwise the captured broadcast data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discards every held entry |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_ready | output | 1 | Station can take the offered instruction |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_a_rdy | input | 1 | Source A value is present at dispatch |
| disp_a_tag | input | TAG_W | Rename tag awaited by source A |
| disp_a_data | input | DATA_W | Source A value when present |
| disp_b_rdy | input | 1 | Source B value is present at dispatch |
| disp_b_tag | input | TAG_W | Rename tag awaited by source B |
| disp_b_data | input | DATA_W | Source B value when present |
| bc_valid | input | 1 | A result is being broadcast |
| bc_tag | input | TAG_W | Rename tag of the broadcast result |
| bc_data | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | An instruction is offered to the execution unit |
| iss_ready | input | 1 | Execution unit accepts the offered instruction |
| iss_op | output | OP_W | Opcode of the offered instruction |
| iss_a | output | DATA_W | Source A value of the offered instruction |
| iss_b | output | DATA_W | Source B value of the offered instruction |

## Verification
The bench runs one station in each policy from the same stimulus. It puts a ready younger entry behind a stalled older one: an in-order station that let the younger entry through, or an out-of-order station that held it back, would show the wrong `iss_valid` or opcode. It sends a broadcast in the same cycle as the dispatch that needs it, and checks that a wakeup does not show up in the broadcast cycle itself. A design that dropped the capture would hang with `iss_valid` low, and one that bypassed the broadcast would issue a cycle early. It also fills both slots and then issues while dispatching. A `disp_ready` that ignored the issue handshake would refuse the refill, and one that ignored occupancy would overwrite a live entry; either would then offer a wrong opcode. Flush tests check that a cleared entry is not revived by a later broadcast of its tag.

// File: rtl/opw_pkg.sv
package opw_pkg;

  typedef enum logic {
    POLICY_IN_ORDER     = 1'b0,
    POLICY_OUT_OF_ORDER = 1'b1
  } policy_e;

  localparam int ENTRIES = 2;
  localparam int SRCS    = 2;

endpackage

// File: rtl/opw_src_match.sv
module opw_src_match #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              cur_rdy,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic [DATA_W-1:0] cur_dat,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              nxt_rdy,
  output logic [DATA_W-1:0] nxt_dat
);

  logic hit;

  assign hit     = !cur_rdy && bc_valid && (bc_tag == cur_tag);
  assign nxt_rdy = cur_rdy || hit;
  assign nxt_dat = hit ? bc_data : cur_dat;

endmodule

// File: rtl/opw_pick.sv
module opw_pick #(
  parameter bit OLDEST_ONLY = 1'b0
) (
  input  logic [1:0] cand,
  output logic       any,
  output logic       sel
);

  generate
    if (OLDEST_ONLY) begin : g_oldest
      // slot 0 always holds the oldest entry
      assign any = cand[0];
      assign sel = 1'b0;
    end else begin : g_first_ready
      assign any = |cand;
      assign sel = !cand[0];
    end
  endgenerate

endmodule

// File: rtl/opwait_station.sv
module opwait_station
  import opw_pkg::*;
#(
  parameter int      TAG_W  = 4,
  parameter int      DATA_W = 16,
  parameter int      OP_W   = 6,
  parameter policy_e POLICY = POLICY_OUT_OF_ORDER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [OP_W-1:0]   disp_op,
  input  logic              disp_a_rdy,
  input  logic [TAG_W-1:0]  disp_a_tag,
  input  logic [DATA_W-1:0] disp_a_data,
  input  logic              disp_b_rdy,
  input  logic [TAG_W-1:0]  disp_b_tag,
  input  logic [DATA_W-1:0] disp_b_data,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [OP_W-1:0]   iss_op,
  output logic [DATA_W-1:0] iss_a,
  output logic [DATA_W-1:0] iss_b
);

  localparam bit IN_ORDER = (POLICY == POLICY_IN_ORDER);

  // held state, slot 0 is always the older entry
  logic              slot_vld [ENTRIES];
  logic [OP_W-1:0]   slot_op  [ENTRIES];
  logic              slot_rdy [ENTRIES][SRCS];
  logic [TAG_W-1:0]  slot_tag [ENTRIES][SRCS];
  logic [DATA_W-1:0] slot_dat [ENTRIES][SRCS];

  // state after this cycle's broadcast
  logic              w_rdy [ENTRIES][SRCS];
  logic [DATA_W-1:0] w_dat [ENTRIES][SRCS];

  // incoming instruction, raw and after broadcast
  logic              d_rdy_in [SRCS];
  logic [TAG_W-1:0]  d_tag_in [SRCS];
  logic [DATA_W-1:0] d_dat_in [SRCS];
  logic              d_rdy    [SRCS];
  logic [DATA_W-1:0] d_dat    [SRCS];

  // next state
  logic              n_vld [ENTRIES];
  logic [OP_W-1:0]   n_op  [ENTRIES];
  logic              n_rdy [ENTRIES][SRCS];
  logic [TAG_W-1:0]  n_tag [ENTRIES][SRCS];
  logic [DATA_W-1:0] n_dat [ENTRIES][SRCS];

  logic [ENTRIES-1:0] cand;
  logic [ENTRIES-1:0] occ_vec;
  logic               pick_any;
  logic               pick_sel;
  logic               in_order_mode;
  logic               fire;
  logic               accept;
  logic               both_held;
  logic               ins_idx;

  assign in_order_mode = IN_ORDER;

  assign d_rdy_in[0] = disp_a_rdy;
  assign d_tag_in[0] = disp_a_tag;
  assign d_dat_in[0] = disp_a_data;
  assign d_rdy_in[1] = disp_b_rdy;
  assign d_tag_in[1] = disp_b_tag;
  assign d_dat_in[1] = disp_b_data;

  genvar gs, gk;
  generate
    for (gs = 0; gs < ENTRIES; gs++) begin : g_slot
      for (gk = 0; gk < SRCS; gk++) begin : g_src
        opw_src_match #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake (
          .cur_rdy  (slot_rdy[gs][gk]),
          .cur_tag  (slot_tag[gs][gk]),
          .cur_dat  (slot_dat[gs][gk]),
          .bc_valid (bc_valid),
          .bc_tag   (bc_tag),
          .bc_data  (bc_data),
          .nxt_rdy  (w_rdy[gs][gk]),
          .nxt_dat  (w_dat[gs][gk])
        );
      end
      // eligibility uses registered readiness only: wakeup is one cycle late
      assign cand[gs]    = slot_vld[gs] && slot_rdy[gs][0] && slot_rdy[gs][1];
      assign occ_vec[gs] = slot_vld[gs];
    end

    for (gk = 0; gk < SRCS; gk++) begin : g_disp_src
      opw_src_match #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake_in (
        .cur_rdy  (d_rdy_in[gk]),
        .cur_tag  (d_tag_in[gk]),
        .cur_dat  (d_dat_in[gk]),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data),
        .nxt_rdy  (d_rdy[gk]),
        .nxt_dat  (d_dat[gk])
      );
    end
  endgenerate

  opw_pick #(.OLDEST_ONLY(IN_ORDER)) u_pick (
    .cand (cand),
    .any  (pick_any),
    .sel  (pick_sel)
  );

  assign both_held  = slot_vld[0] && slot_vld[1];
  assign iss_valid  = !flush && pick_any;
  assign fire       = iss_valid && iss_ready;
  assign disp_ready = !flush && (!both_held || fire);
  assign accept     = disp_valid && disp_ready;

  assign iss_op = slot_op[pick_sel];
  assign iss_a  = slot_dat[pick_sel][0];
  assign iss_b  = slot_dat[pick_sel][1];

  always_comb begin
    for (int s = 0; s < ENTRIES; s++) begin
      n_vld[s] = slot_vld[s];
      n_op[s]  = slot_op[s];
      for (int k = 0; k < SRCS; k++) begin
        n_rdy[s][k] = w_rdy[s][k];
        n_tag[s][k] = slot_tag[s][k];
        n_dat[s][k] = w_dat[s][k];
      end
    end

    // remove the issued entry, shifting the younger one down if needed
    if (fire) begin
      if (!pick_sel) begin
        n_vld[0] = slot_vld[1];
        n_op[0]  = slot_op[1];
        for (int k = 0; k < SRCS; k++) begin
          n_rdy[0][k] = w_rdy[1][k];
          n_tag[0][k] = slot_tag[1][k];
          n_dat[0][k] = w_dat[1][k];
        end
      end
      n_vld[1] = 1'b0;
    end

    // append the new instruction behind whatever remains
    ins_idx = n_vld[0];
    if (accept) begin
      n_vld[ins_idx] = 1'b1;
      n_op[ins_idx]  = disp_op;
      for (int k = 0; k < SRCS; k++) begin
        n_rdy[ins_idx][k] = d_rdy[k];
        n_tag[ins_idx][k] = d_tag_in[k];
        n_dat[ins_idx][k] = d_dat[k];
      end
    end

    if (flush) begin
      for (int s = 0; s < ENTRIES; s++) n_vld[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < ENTRIES; s++) begin
        slot_vld[s] <= 1'b0;
        slot_op[s]  <= '0;
        for (int k = 0; k < SRCS; k++) begin
          slot_rdy[s][k] <= 1'b0;
          slot_tag[s][k] <= '0;
          slot_dat[s][k] <= '0;
        end
      end
    end else begin
      for (int s = 0; s < ENTRIES; s++) begin
        slot_vld[s] <= n_vld[s];
        slot_op[s]  <= n_op[s];
        for (int k = 0; k < SRCS; k++) begin
          slot_rdy[s][k] <= n_rdy[s][k];
          slot_tag[s][k] <= n_tag[s][k];
          slot_dat[s][k] <= n_dat[s][k];
        end
      end
    end
  end

endmodule

// File: rtl/opw_station_chk.sv
module opw_station_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic       disp_ready,
  input logic       iss_valid,
  input logic       iss_ready,
  input logic       iss_sel,
  input logic [1:0] occ,
  input logic       in_order
);

  assert_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(occ[0] && occ[1])) |-> disp_ready);

  assert_full_backpressure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ[0] && occ[1] && !(iss_valid && iss_ready)) |-> !disp_ready);

  assert_oldest_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_order && iss_valid) |-> !iss_sel);

  assert_program_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ[1] |-> occ[0]);

  assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !flush) |=> (iss_valid || flush));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == 2'b00));

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!iss_valid && !disp_ready));

endmodule

bind opwait_station opw_station_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .disp_ready (disp_ready),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_sel    (pick_sel),
  .occ        (occ_vec),
  .in_order   (in_order_mode)
);

// File: tb/test_opwait_station.sv
`timescale 1ns/1ps
module test_opwait_station;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        disp_valid = 1'b0;
  logic [5:0]  disp_op = '0;
  logic        disp_a_rdy = 1'b0, disp_b_rdy = 1'b0;
  logic [3:0]  disp_a_tag = '0, disp_b_tag = '0;
  logic [15:0] disp_a_data = '0, disp_b_data = '0;
  logic        bc_valid = 1'b0;
  logic [3:0]  bc_tag = '0;
  logic [15:0] bc_data = '0;
  logic        iss_ready = 1'b0;

  logic        o_disp_ready, o_iss_valid, n_disp_ready, n_iss_valid;
  logic [5:0]  o_iss_op, n_iss_op;
  logic [15:0] o_iss_a, o_iss_b, n_iss_a, n_iss_b;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  opwait_station #(.POLICY(opw_pkg::POLICY_OUT_OF_ORDER)) i_opwait_station (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(o_disp_ready), .disp_op(disp_op),
    .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_data(disp_a_data),
    .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_data(disp_b_data),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .iss_valid(o_iss_valid), .iss_ready(iss_ready),
    .iss_op(o_iss_op), .iss_a(o_iss_a), .iss_b(o_iss_b)
  );

  opwait_station #(.POLICY(opw_pkg::POLICY_IN_ORDER)) i_opwait_station_ino (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(n_disp_ready), .disp_op(disp_op),
    .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_data(disp_a_data),
    .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_data(disp_b_data),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .iss_valid(n_iss_valid), .iss_ready(iss_ready),
    .iss_op(n_iss_op), .iss_a(n_iss_a), .iss_b(n_iss_b)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic drive(input logic [5:0] op,
                       input logic ar, input logic [3:0] at, input logic [15:0] ad,
                       input logic br, input logic [3:0] bt, input logic [15:0] bd);
    disp_valid = 1'b1; disp_op = op;
    disp_a_rdy = ar; disp_a_tag = at; disp_a_data = ad;
    disp_b_rdy = br; disp_b_tag = bt; disp_b_data = bd;
  endtask

  task automatic idle_disp;
    disp_valid = 1'b0;
  endtask

  task automatic bcast(input logic v, input logic [3:0] t, input logic [15:0] d);
    bc_valid = v; bc_tag = t; bc_data = d;
  endtask

  task automatic do_flush;
    idle_disp(); bcast(1'b0, 4'h0, 16'h0); iss_ready = 1'b0;
    flush = 1'b1;
    settle();
    check("R9", "ooo disp_ready during flush", {31'b0, o_disp_ready}, 32'd0);
    check("R9", "ino iss_valid during flush", {31'b0, n_iss_valid}, 32'd0);
    tick();
    flush = 1'b0;
    settle();
  endtask

  task automatic t_reset;
    settle();
    check("R1", "ooo iss_valid after reset", {31'b0, o_iss_valid}, 32'd0);
    check("R1", "ooo disp_ready after reset", {31'b0, o_disp_ready}, 32'd1);
    check("R1", "ino iss_valid after reset", {31'b0, n_iss_valid}, 32'd0);
    check("R1", "ino disp_ready after reset", {31'b0, n_disp_ready}, 32'd1);
  endtask

  task automatic t_pending_wake;
    drive(6'd1, 1'b1, 4'h0, 16'h1111, 1'b0, 4'h5, 16'h0);
    settle();
    check("R2", "accept with pending source", {31'b0, o_disp_ready}, 32'd1);
    tick(); idle_disp(); bcast(1'b1, 4'h6, 16'hdead);
    settle(); tick(); bcast(1'b1, 4'h5, 16'h2222);
    settle();
    check("R4", "non-matching tag leaves entry waiting", {31'b0, o_iss_valid}, 32'd0);
    tick(); bcast(1'b0, 4'h0, 16'h0);
    settle();
    check("R4", "ready the cycle after broadcast", {31'b0, o_iss_valid}, 32'd1);
    check("R10", "issued opcode", {26'b0, o_iss_op}, 32'd1);
    check("R10", "dispatched operand A", {16'b0, o_iss_a}, 32'h1111);
    check("R10", "captured operand B", {16'b0, o_iss_b}, 32'h2222);
    iss_ready = 1'b1; settle(); tick(); iss_ready = 1'b0; settle();
    check("R8", "entry gone after handshake", {31'b0, o_iss_valid}, 32'd0);
    do_flush();
  endtask

  task automatic t_same_cycle;
    drive(6'd2, 1'b0, 4'h3, 16'h0, 1'b0, 4'h4, 16'h0);
    bcast(1'b1, 4'h3, 16'h3333);
    settle(); tick(); idle_disp(); bcast(1'b1, 4'h4, 16'h4444);
    settle();
    check("R4", "no issue in broadcast cycle", {31'b0, o_iss_valid}, 32'd0);
    tick(); bcast(1'b0, 4'h0, 16'h0); settle();
    check("R5", "same-cycle capture lets entry issue", {31'b0, o_iss_valid}, 32'd1);
    check("R5", "operand caught at dispatch", {16'b0, o_iss_a}, 32'h3333);
    check("R10", "operand B captured later", {16'b0, o_iss_b}, 32'h4444);
    do_flush();
  endtask

  task automatic t_backpressure;
    drive(6'd3, 1'b0, 4'h1, 16'h0, 1'b1, 4'h0, 16'h0303);
    settle(); tick();
    drive(6'd4, 1'b0, 4'h2, 16'h0, 1'b1, 4'h0, 16'h0404);
    settle();
    check("R2", "room for second entry", {31'b0, o_disp_ready}, 32'd1);
    tick(); idle_disp(); settle();
    check("R3", "ooo full stalls dispatch", {31'b0, o_disp_ready}, 32'd0);
    check("R3", "ino full stalls dispatch", {31'b0, n_disp_ready}, 32'd0);
    bcast(1'b1, 4'h2, 16'h5555); settle(); tick(); bcast(1'b0, 4'h0, 16'h0);
    drive(6'd5, 1'b1, 4'h0, 16'h0505, 1'b1, 4'h0, 16'h0506);
    iss_ready = 1'b1; settle();
    check("R7", "younger ready entry offered", {26'b0, o_iss_op}, 32'd4);
    check("R3", "issuing frees a slot for dispatch", {31'b0, o_disp_ready}, 32'd1);
    check("R3", "ino full, older stalled", {31'b0, n_disp_ready}, 32'd0);
    tick(); idle_disp(); iss_ready = 1'b0; settle();
    check("R3", "refilled station full again", {31'b0, o_disp_ready}, 32'd0);
    check("R7", "refill entry offered over stalled older", {26'b0, o_iss_op}, 32'd5);
    do_flush();
  endtask

  task automatic t_order_policies;
    drive(6'd10, 1'b0, 4'h7, 16'h0, 1'b1, 4'h0, 16'h0a0a);
    settle(); tick();
    drive(6'd11, 1'b1, 4'h0, 16'h0b01, 1'b1, 4'h0, 16'h0b02);
    settle(); tick(); idle_disp(); settle();
    check("R7", "ooo offers ready younger", {31'b0, o_iss_valid}, 32'd1);
    check("R7", "ooo younger opcode", {26'b0, o_iss_op}, 32'd11);
    check("R10", "ooo younger operand B", {16'b0, o_iss_b}, 32'h0b02);
    check("R6", "ino holds younger behind stalled older", {31'b0, n_iss_valid}, 32'd0);
    iss_ready = 1'b1; settle(); tick(); iss_ready = 1'b0; settle();
    check("R8", "ooo one issue then idle", {31'b0, o_iss_valid}, 32'd0);
    check("R6", "ino still blocked", {31'b0, n_iss_valid}, 32'd0);
    bcast(1'b1, 4'h7, 16'h0a07); settle(); tick(); bcast(1'b0, 4'h0, 16'h0); settle();
    check("R6", "ino oldest first", {26'b0, n_iss_op}, 32'd10);
    check("R4", "ino woken operand A", {16'b0, n_iss_a}, 32'h0a07);
    check("R7", "ooo remaining entry", {26'b0, o_iss_op}, 32'd10);
    iss_ready = 1'b1; settle(); tick(); settle();
    check("R6", "ino younger follows", {26'b0, n_iss_op}, 32'd11);
    check("R8", "ooo empty after its second issue", {31'b0, o_iss_valid}, 32'd0);
    tick(); iss_ready = 1'b0; settle();
    check("R8", "ino empty after two issues", {31'b0, n_iss_valid}, 32'd0);
    do_flush();
  endtask

  task automatic t_both_ready_hold;
    drive(6'd20, 1'b1, 4'h0, 16'h0001, 1'b1, 4'h0, 16'h0002);
    settle(); tick();
    drive(6'd21, 1'b1, 4'h0, 16'h0003, 1'b1, 4'h0, 16'h0004);
    settle(); tick(); idle_disp(); settle();
    check("R7", "older wins when both ready", {26'b0, o_iss_op}, 32'd20);
    for (int i = 0; i < 3; i++) begin
      tick(); settle();
      check("R8", "offer held under back-pressure", {31'b0, o_iss_valid}, 32'd1);
      check("R8", "held opcode", {26'b0, o_iss_op}, 32'd20);
    end
    iss_ready = 1'b1; settle(); tick(); settle();
    check("R8", "one per cycle, second remains", {26'b0, o_iss_op}, 32'd21);
    check("R6", "ino second in order", {26'b0, n_iss_op}, 32'd21);
    tick(); iss_ready = 1'b0; settle();
    check("R8", "both issued", {31'b0, o_iss_valid}, 32'd0);
    check("R2", "empty station ready", {31'b0, o_disp_ready}, 32'd1);
    do_flush();
  endtask

  task automatic t_flush;
    drive(6'd30, 1'b1, 4'h0, 16'h0030, 1'b1, 4'h0, 16'h0031);
    settle(); tick();
    drive(6'd31, 1'b0, 4'h8, 16'h0, 1'b1, 4'h0, 16'h0032);
    settle(); tick(); idle_disp();
    flush = 1'b1; settle();
    check("R9", "no offer during flush", {31'b0, o_iss_valid}, 32'd0);
    check("R9", "no dispatch during flush", {31'b0, o_disp_ready}, 32'd0);
    tick(); flush = 1'b0; bcast(1'b1, 4'h8, 16'h0808); settle();
    check("R9", "ready station after flush", {31'b0, o_disp_ready}, 32'd1);
    check("R9", "nothing offered after flush", {31'b0, o_iss_valid}, 32'd0);
    tick(); bcast(1'b0, 4'h0, 16'h0); settle();
    check("R9", "broadcast does not revive ooo", {31'b0, o_iss_valid}, 32'd0);
    check("R9", "broadcast does not revive ino", {31'b0, n_iss_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pending_wake();
    t_same_cycle();
    t_backpressure();
    t_order_policies();
    t_both_ready_hold();
    t_flush();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule